// File: doc/BRIEF.md
# Bank-Switched Memory Softswitch Controller

This block watches the processor bus and keeps the state of a small RAM region that can overlay ROM. A 16-location switch window in the I/O page controls three things. The first is whether reads of the overlay region come from RAM or from ROM. The second is which of two alternate 4K banks is mapped in. The third is whether RAM in the region accepts writes. The block decodes each valid bus cycle and updates these three flags. The address decoders and the data path of the memory system use the flags.

Turning RAM writes on is guarded. From the off state, two reads to a write-enabling switch are needed, with no bus write between them. A read-modify-write instruction issues two reads and then a write. That sequence must qualify exactly as its bus cycles dictate. Once writes are on, a single read to any write-enabling switch keeps them on, even if that read also changes the bank or the read source. A bus write to the window can change the bank and the read source, but it never turns RAM writes on.

Top module: `bankswitch_ctl`

## Requirements
- R1: Only cycles with `bus_valid` high and an address in 0xC080–0xC08F act on the switches. Any other cycle leaves all three outputs unchanged. Reads outside the window do not disturb a pending two-read qualification.
- R2: A window access sets `bank_one_sel` to address bit 3. A value of 1 selects bank 1 (switches 0x88–0x8F) and 0 selects bank 2 (switches 0x80–0x87).
- R3: A window access sets `rd_from_ram` to 1 when the two low address bits are 00 or 11, and to 0 (ROM) when they are 01 or 10.
- R4: Address bit 2 is ignored. 0x84–0x87 behave exactly like 0x80–0x83, and 0x8C–0x8F behave exactly like 0x88–0x8B.
- R5: Any access, read or write, to a window location with address bit 0 equal to 0 clears `ram_wr_en` and the qualification counter.
- R6: With `ram_wr_en` off, a single read to a window location with address bit 0 equal to 1 leaves it off. A second such read with no valid write cycle between the two turns it on.
- R7: A valid write cycle to any address clears the qualification counter, so two fresh qualifying reads are needed afterwards.
- R8: With `ram_wr_en` on, one read to a location with bit 0 equal to 1 keeps it on, whatever bank or read source that read selects.
- R9: A write to a location with bit 0 equal to 1 updates the bank and the read source, and leaves `ram_wr_en` unchanged. In particular, it never turns it on.
- R10: While `rst_n` is low, the outputs are `bank_one_sel`=0, `rd_from_ram`=0 and `ram_wr_en`=1, and the counter is cleared.
- R11: The cycle sequence read, read, write to the same location with bit 0 equal to 1, starting from writes off, leaves `ram_wr_en` on.
- R12: All outputs are registered. They change on the clock edge that samples the qualifying cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Bus cycle address |
| bus_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_valid | input | 1 | Bus cycle is valid in this clock |
| rd_from_ram | output | 1 | 1 = overlay reads come from RAM, 0 = ROM |
| ram_wr_en | output | 1 | Overlay RAM accepts writes |
| bank_one_sel | output | 1 | 1 = bank 1, 0 = bank 2 |

## Verification
The main sweep starts from a known disabled state and runs every ordered pair of window locations, with each of the four read/write combinations. This separates the effect of the bank bit, the read-source bits and the write-enable bit. It also covers both aliases of each switch, and it shows which pairs qualify and which are cancelled. Directed sequences then check four cases. The first is a stray write between the two reads, placed outside the window. The second is an out-of-window read between the two reads, which does not cancel them. The third is the read-read-write pattern of a read-modify-write instruction. The fourth is the case where writes are already on and a single access changes the bank or the read source. Idle cycles and cycles with `bus_valid` low are mixed in to show that they change nothing.

// File: rtl/bankswitch_ctl.sv
module bankswitch_ctl #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] WIN_BASE = 16'hC080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_valid,
  output logic              rd_from_ram,
  output logic              ram_wr_en,
  output logic              bank_one_sel
);

  logic in_win, sel_odd, rd_hit, pre_q;
  logic src_ram_n, wen_n, pre_n;

  assign in_win    = bus_valid && (bus_addr[ADDR_W-1:4] == WIN_BASE[ADDR_W-1:4]);
  assign sel_odd   = bus_addr[0];
  assign rd_hit    = in_win && !bus_wr && sel_odd;
  assign src_ram_n = (bus_addr[1] == bus_addr[0]);

  always_comb begin
    wen_n = ram_wr_en;
    pre_n = pre_q;
    if (bus_valid && bus_wr) pre_n = 1'b0;
    if (in_win && !sel_odd) begin
      wen_n = 1'b0;
      pre_n = 1'b0;
    end else if (rd_hit) begin
      wen_n = ram_wr_en | pre_q;
      pre_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_one_sel <= 1'b0;
      rd_from_ram  <= 1'b0;
      ram_wr_en    <= 1'b1;
      pre_q        <= 1'b0;
    end else begin
      if (in_win) begin
        bank_one_sel <= bus_addr[3];
        rd_from_ram  <= src_ram_n;
      end
      ram_wr_en <= wen_n;
      pre_q     <= pre_n;
    end
  end

endmodule

module bankswitch_ctl_chk #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] WIN_BASE = 16'hC080
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_valid,
  input logic              rd_from_ram,
  input logic              ram_wr_en,
  input logic              bank_one_sel
);
  logic hit;
  assign hit = bus_valid && (bus_addr[ADDR_W-1:4] == WIN_BASE[ADDR_W-1:4]);

  p_outside_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(bank_one_sel) && $stable(rd_from_ram));

  p_bank_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> bank_one_sel == $past(bus_addr[3]));

  p_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> rd_from_ram == ($past(bus_addr[1]) == $past(bus_addr[0])));

  p_even_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !bus_addr[0] |=> !ram_wr_en);

  p_enable_by_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_wr_en) |-> $past(hit && !bus_wr && bus_addr[0]));

  p_keep_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !bus_wr && bus_addr[0] && ram_wr_en |=> ram_wr_en);

  p_write_no_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_wr && !ram_wr_en |=> !ram_wr_en);
endmodule

bind bankswitch_ctl bankswitch_ctl_chk #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_valid(bus_valid), .rd_from_ram(rd_from_ram), .ram_wr_en(ram_wr_en),
  .bank_one_sel(bank_one_sel));

// File: tb/tb_bankswitch_ctl.sv
module tb_bankswitch_ctl;
  logic clk = 0, rst_n = 0;
  logic [15:0] bus_addr = 16'h0;
  logic bus_wr = 0, bus_valid = 0;
  logic rd_from_ram, ram_wr_en, bank_one_sel;
  int checks = 0, fails = 0, cycles = 0;
  bit m_bank, m_ram, m_wen, m_pre;

  always #4 clk = ~clk;

  bankswitch_ctl dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_valid(bus_valid), .rd_from_ram(rd_from_ram), .ram_wr_en(ram_wr_en),
    .bank_one_sel(bank_one_sel));

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model(logic [15:0] a, bit w, bit v);
    bit hit = v && (a[15:4] == 12'hC08);
    if (v && w) m_pre = 0;
    if (hit) begin
      m_bank = a[3];
      m_ram  = (a[1] == a[0]);
      if (!a[0]) begin m_wen = 0; m_pre = 0; end
      else if (!w) begin m_wen = m_wen | m_pre; m_pre = 1; end
    end
  endtask

  task automatic cyc(logic [15:0] a, bit w, bit v = 1);
    bus_addr = a; bus_wr = w; bus_valid = v;
    @(negedge clk);
    model(a, w, v);
  endtask

  task automatic all3(string tag);
    chk({tag, "/R2 bank"}, bank_one_sel, m_bank);
    chk({tag, "/R3 src"}, rd_from_ram, m_ram);
    chk({tag, "/R6 wen"}, ram_wr_en, m_wen);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 bank", bank_one_sel, 1'b0);
    chk("R10 src", rd_from_ram, 1'b0);
    chk("R10 wen", ram_wr_en, 1'b1);
    rst_n = 1;
    m_bank = 0; m_ram = 0; m_wen = 1; m_pre = 0;
    cyc(16'hC081, 0);
    chk("R10 wen after one read", ram_wr_en, 1'b1);

    // exhaustive pairs from a disabled state
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int op = 0; op < 4; op++) begin
          cyc(16'hC080, 0);
          cyc(16'hC080 | 16'(a), op[0]);
          all3("R1 sweep1");
          cyc(16'hC080 | 16'(b), op[1]);
          all3("R1 sweep2");
        end

    // R12 / R6: single read does not enable; output timing
    cyc(16'hC088, 0);
    bus_addr = 16'hC08B; bus_wr = 0; bus_valid = 1;
    @(posedge clk); #1;
    chk("R12 bank after edge", bank_one_sel, 1'b1);
    @(negedge clk); model(16'hC08B, 0, 1);
    chk("R6 single read off", ram_wr_en, 1'b0);
    cyc(16'hC08B, 0);
    chk("R6 second read on", ram_wr_en, 1'b1);

    // R7: stray write outside window cancels
    cyc(16'hC080, 0);
    cyc(16'hC081, 0);
    cyc(16'h1234, 1);
    cyc(16'hC081, 0);
    chk("R7 write between cancels", ram_wr_en, 1'b0);
    cyc(16'hC081, 0);
    chk("R7 two fresh reads", ram_wr_en, 1'b1);

    // R1: outside read and invalid cycles don't cancel or change state
    cyc(16'hC080, 0);
    cyc(16'hC083, 0);
    cyc(16'h2000, 0);
    cyc(16'hC088, 1, 0);
    chk("R1 invalid no bank change", bank_one_sel, 1'b0);
    cyc(16'hC083, 0);
    chk("R1 outside read keeps count", ram_wr_en, 1'b1);
    cyc(16'hC08F, 0, 0);
    all3("R1 invalid ignored");

    // R4 alias
    cyc(16'hC080, 0);
    cyc(16'hC08F, 0);
    cyc(16'hC08B, 0);
    chk("R4 alias qualifies", ram_wr_en, 1'b1);
    chk("R4 alias bank", bank_one_sel, 1'b1);

    // R8: enabled state survives bank and source change
    cyc(16'hC083, 0);
    chk("R8 bank2", bank_one_sel, 1'b0);
    cyc(16'hC08B, 0);
    chk("R8 bank change keeps wen", ram_wr_en, 1'b1);
    chk("R8 bank1", bank_one_sel, 1'b1);
    cyc(16'hC081, 0);
    cyc(16'hC083, 0);
    chk("R8 source change keeps wen", ram_wr_en, 1'b1);
    chk("R8 source ram", rd_from_ram, 1'b1);

    // R9: writes change banking but never enable
    cyc(16'hC080, 1);
    chk("R5 even write clears", ram_wr_en, 1'b0);
    cyc(16'hC08B, 1);
    cyc(16'hC08B, 1);
    chk("R9 write no enable", ram_wr_en, 1'b0);
    chk("R9 write sets bank", bank_one_sel, 1'b1);
    chk("R9 write sets source", rd_from_ram, 1'b1);
    cyc(16'hC081, 0); cyc(16'hC081, 0);
    cyc(16'hC089, 1);
    chk("R9 odd write keeps on", ram_wr_en, 1'b1);

    // R11: read-modify-write pattern
    cyc(16'hC082, 0);
    cyc(16'hC081, 0);
    cyc(16'hC081, 0);
    cyc(16'hC081, 1);
    chk("R11 rmw enables", ram_wr_en, 1'b1);
    all3("R11 model");

    // R5 even read clears when on
    cyc(16'hC08A, 0);
    chk("R5 even read clears", ram_wr_en, 1'b0);

    bus_valid = 0;
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule